// File: doc/BRIEF.md
# Gated Event Counter with Selectable Gate and Toggle Stage

This block is a 16-bit up-counter that advances on a count-enable tick, optionally only while a gate is active. The gate comes from one of four sources: an external gate pin, a match pulse from a small built-in period timer, or one of two comparator outputs, which arrive as plain digital inputs. The asynchronous sources are synchronized into the core clock first. The chosen source then goes through a programmable polarity inverter and an optional toggle stage.

With the toggle stage enabled, every rising edge of the polarity-adjusted gate flips a flip-flop. The counter then runs for one whole gate period and rests for the next one, so it measures a full cycle instead of a single level. With the stage disabled, the flip-flop is forced clear, which fixes the edge that opens the next measurement.

All configuration arrives on input ports. The period timer exists only to produce the match pulse. The counter can be loaded synchronously, wraps with a one-cycle overflow flag, and reports the effective gate on a registered status output.

Top module: `gate_timer`

## Requirements
- R1: A synchronous active-high reset clears the count, the overflow flag, the gate status, the toggle flip-flop and the period timer.
- R2: While `gate_en` is 0, the count increments by one on every cycle with `cnt_tick` high, whatever the gate sources do.
- R3: `gate_sel` picks the gate source: 2'b00 the synchronized `gate_pin`, 2'b01 the period-match pulse, 2'b10 the synchronized `cmp1`, 2'b11 the synchronized `cmp2`. While `gate_en` is 1, the count increments on a tick only if the effective gate is 1.
- R4: With `gate_inv` = 1 the selected source is active-low, and with `gate_inv` = 0 it is active-high.
- R5: The period timer advances on each `per_tick`. When its count equals `per_value`, the next tick returns it to zero and raises the match pulse for exactly one cycle. With `per_value` = 3 and `per_tick` held high from reset, the pulse is high in cycles 5, 9, 13 and so on.
- R6: With `toggle_en` = 1, each rising edge of the polarity-adjusted gate flips the toggle flip-flop, and the flip-flop output is the effective gate. The counter therefore counts for one full gate period and pauses for the next.
- R7: While `toggle_en` = 0 the toggle flip-flop is held at 0, so re-enabling toggle mode without a new gate edge leaves the gate inactive.
- R8: `gate_val` shows the effective gate, registered one cycle after it.
- R9: An increment from 16'hFFFF gives 16'h0000 and raises `overflow` for exactly that one cycle.
- R10: `load` writes `load_value` into the count on the next edge. When `load` and an increment fall in the same cycle, the load wins and no increment happens.
- R11: With `load` low and `cnt_tick` low, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count-enable tick |
| gate_en | input | 1 | 1: gating applies; 0: count on every tick |
| gate_sel | input | 2 | Gate source select |
| gate_inv | input | 1 | 1: selected source is active-low |
| toggle_en | input | 1 | Enables the toggle stage |
| gate_pin | input | 1 | External gate input, asynchronous |
| cmp1 | input | 1 | Comparator 1 output, asynchronous |
| cmp2 | input | 1 | Comparator 2 output, asynchronous |
| per_tick | input | 1 | Period timer increment tick |
| per_value | input | 8 | Period timer match value |
| load | input | 1 | Synchronous count load |
| load_value | input | 16 | Value written by load |
| count | output | 16 | Counter value |
| overflow | output | 1 | One-cycle wrap flag |
| gate_val | output | 1 | Registered effective gate |

## Verification
Two functions can fall in the same cycle: a load and an increment. The bench provokes this by raising `load` and `cnt_tick` together while gating is off. It then checks that the count equals the loaded value with no extra step.

A wrap and a plain increment also meet at 16'hFFFF. The bench steps through that point one cycle at a time and checks that the overflow flag is set only in the cycle where the count reads zero.

// File: rtl/gate_timer_pkg.sv
package gate_timer_pkg;
  typedef enum logic [1:0] {
    SRC_PIN    = 2'b00,
    SRC_PERIOD = 2'b01,
    SRC_CMP1   = 2'b10,
    SRC_CMP2   = 2'b11
  } gate_src_e;
endpackage

// File: rtl/gt_sync.sv
module gt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gt_period.sv
module gt_period #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          pulse
);
  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt  <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      if (pcnt >= period) begin
        pcnt  <= '0;
        pulse <= 1'b1;
      end else begin
        pcnt  <= pcnt + PW'(1);
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/gt_gate.sv
module gt_gate
  import gate_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  gate_src_e sel,
  input  logic      inv,
  input  logic      tgl_en,
  input  logic      pin_s,
  input  logic      cmp1_s,
  input  logic      cmp2_s,
  input  logic      pm_pulse,
  output logic      eff,
  output logic      tgl_q
);
  logic raw, pol, pol_d, rise;

  always_comb begin
    unique case (sel)
      SRC_PIN:    raw = pin_s;
      SRC_PERIOD: raw = pm_pulse;
      SRC_CMP1:   raw = cmp1_s;
      SRC_CMP2:   raw = cmp2_s;
      default:    raw = 1'b0;
    endcase
  end

  assign pol  = raw ^ inv;
  assign rise = pol & ~pol_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_d <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      pol_d <= pol;
      tgl_q <= tgl_en ? (tgl_q ^ rise) : 1'b0;
    end
  end

  assign eff = tgl_en ? tgl_q : pol;
endmodule

// File: rtl/gt_count.sv
module gt_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_value,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (load) begin
      count <= load_value;
      ovf   <= 1'b0;
    end else if (inc) begin
      count <= count + W'(1);
      ovf   <= (count == TOP);
    end else begin
      ovf   <= 1'b0;
    end
  end
endmodule

// File: rtl/gate_timer.sv
module gate_timer
  import gate_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic             gate_en,
  input  logic [1:0]       gate_sel,
  input  logic             gate_inv,
  input  logic             toggle_en,
  input  logic             gate_pin,
  input  logic             cmp1,
  input  logic             cmp2,
  input  logic             per_tick,
  input  logic [PER_W-1:0] per_value,
  input  logic             load,
  input  logic [CNT_W-1:0] load_value,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             gate_val
);
  localparam int NASYNC = 3;

  logic [NASYNC-1:0] async_s;
  logic pm_pulse, eff, tgl_q, inc;

  gt_sync #(.W(NASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({cmp2, cmp1, gate_pin}), .q(async_s)
  );

  gt_period #(.PW(PER_W)) u_period (
    .clk(clk), .rst(rst), .tick(per_tick), .period(per_value), .pulse(pm_pulse)
  );

  gt_gate u_gate (
    .clk(clk), .rst(rst), .sel(gate_src_e'(gate_sel)), .inv(gate_inv),
    .tgl_en(toggle_en), .pin_s(async_s[0]), .cmp1_s(async_s[1]),
    .cmp2_s(async_s[2]), .pm_pulse(pm_pulse), .eff(eff), .tgl_q(tgl_q)
  );

  assign inc = cnt_tick & (~gate_en | eff);

  gt_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .load(load), .load_value(load_value),
    .inc(inc), .count(count), .ovf(overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) gate_val <= 1'b0;
    else     gate_val <= eff;
  end
endmodule

// File: rtl/gate_timer_chk.sv
module gate_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cnt_tick,
  input logic          gate_en,
  input logic          toggle_en,
  input logic          per_tick,
  input logic          load,
  input logic [CW-1:0] load_value,
  input logic [CW-1:0] count,
  input logic          overflow,
  input logic          gate_val,
  input logic          tgl_q,
  input logic          pm_pulse
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !overflow && !gate_val && !tgl_q && !pm_pulse));

  assert_ungated_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_tick && !gate_en) |=> (count == $past(count) + CW'(1)));

  assert_pulse_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
    pm_pulse |-> $past(per_tick));

  assert_toggle_held_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !toggle_en |=> !tgl_q);

  assert_wrap_to_zero_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (count == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> !overflow);

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_value)));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!load && !cnt_tick) |=> $stable(count));
endmodule

bind gate_timer gate_timer_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .gate_en(gate_en),
  .toggle_en(toggle_en), .per_tick(per_tick), .load(load),
  .load_value(load_value), .count(count), .overflow(overflow),
  .gate_val(gate_val), .tgl_q(tgl_q), .pm_pulse(pm_pulse)
);

// File: tb/gate_timer_tb.sv
module gate_timer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_tick = 0, gate_en = 0, gate_inv = 0, toggle_en = 0;
  logic [1:0] gate_sel = 2'b00;
  logic gate_pin = 0, cmp1 = 0, cmp2 = 0, per_tick = 0, load = 0;
  logic [7:0] per_value = 8'd3;
  logic [15:0] load_value = '0;
  logic [15:0] count;
  logic overflow, gate_val;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [15:0] c;
    bit          cg;
    logic        g;
    bit          co;
    logic        o;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  gate_timer u_dut (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .gate_en(gate_en),
    .gate_sel(gate_sel), .gate_inv(gate_inv), .toggle_en(toggle_en),
    .gate_pin(gate_pin), .cmp1(cmp1), .cmp2(cmp2), .per_tick(per_tick),
    .per_value(per_value), .load(load), .load_value(load_value),
    .count(count), .overflow(overflow), .gate_val(gate_val)
  );

  task automatic expect_out(string tag, logic [15:0] c, bit cg, logic g, bit co, logic o);
    exp_t e;
    e.tag = tag; e.c = c; e.cg = cg; e.g = g; e.co = co; e.o = o;
    sb.push_back(e);
  endtask

  // monitor: pops expectations 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (count !== e.c || (e.cg && gate_val !== e.g) || (e.co && overflow !== e.o)) begin
          failures++;
          $display("FAIL %s: count=%h gate_val=%b overflow=%b expected count=%h gate_val=%b overflow=%b",
                   e.tag, count, gate_val, overflow, e.c, e.g, e.o);
        end
      end
    end
  end

  task automatic settle(int n);
    cnt_tick = 0;
    repeat (n) @(negedge clk);
  endtask

  // load l, apply n ticks, expect l+exp_inc
  task automatic measure(string tag, logic [15:0] l, int n, int exp_inc, bit cg, logic g);
    @(negedge clk); load = 1; load_value = l;
    @(negedge clk); load = 0; cnt_tick = 1;
    repeat (n) @(negedge clk);
    cnt_tick = 0;
    expect_out(tag, l + 16'(exp_inc), cg, g, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset state", 16'h0000, 1, 1'b0, 1, 1'b0);
    rst = 0;
    settle(2);

    // R2: ungated counting ignores a low gate
    gate_en = 0; gate_sel = 2'b00; gate_pin = 0;
    measure("R2 ungated count", 16'd100, 10, 10, 0, 0);
    // R11: no tick, count holds
    settle(3);
    expect_out("R11 hold without tick", 16'd110, 0, 0, 0, 0);

    // R3 pin source
    gate_en = 1; gate_sel = 2'b00; gate_pin = 0; settle(4);
    measure("R3 pin low blocks", 16'h0040, 8, 0, 1, 1'b0);
    gate_pin = 1; settle(4);
    measure("R3 pin high counts", 16'h0040, 8, 8, 1, 1'b1);
    // R4 polarity
    gate_inv = 1; settle(4);
    measure("R4 inverted high pin blocks", 16'h0050, 5, 0, 1, 1'b0);
    gate_pin = 0; settle(4);
    measure("R4 inverted low pin counts", 16'h0050, 5, 5, 1, 1'b1);
    gate_inv = 0;
    // R3 comparators
    gate_pin = 0; cmp1 = 1; cmp2 = 0; gate_sel = 2'b10; settle(4);
    measure("R3 cmp1 source counts", 16'h0060, 7, 7, 1, 1'b1);
    gate_sel = 2'b11; settle(4);
    measure("R3 cmp2 low blocks", 16'h0060, 7, 0, 1, 1'b0);
    cmp1 = 0; cmp2 = 1; settle(4);
    measure("R3 cmp2 high counts / R8 status", 16'h0060, 7, 7, 1, 1'b1);
    cmp2 = 0;

    // R9 wrap with one-cycle overflow
    gate_en = 0; settle(2);
    @(negedge clk); load = 1; load_value = 16'hFFFE;
    @(negedge clk); load = 0; cnt_tick = 1;
    @(negedge clk);
    expect_out("R9 at FFFF no flag", 16'hFFFF, 0, 0, 1, 1'b0);
    @(negedge clk); cnt_tick = 0;
    expect_out("R9 wrap to zero with flag", 16'h0000, 0, 0, 1, 1'b1);
    @(negedge clk);
    expect_out("R9 flag one cycle", 16'h0000, 0, 0, 1, 1'b0);

    // R10 load and tick together
    @(negedge clk); load = 1; load_value = 16'h1234; cnt_tick = 1;
    @(negedge clk); load = 0; cnt_tick = 0;
    expect_out("R10 load beats increment", 16'h1234, 0, 0, 0, 0);
    settle(3);
    expect_out("R11 idle after load", 16'h1234, 0, 0, 0, 0);

    // R7 toggle clear
    gate_en = 1; gate_sel = 2'b00; gate_pin = 0; toggle_en = 1; settle(4);
    gate_pin = 1; settle(5);
    expect_out("R6 pin edge sets toggle / R8", 16'h1234, 1, 1'b1, 0, 0);
    toggle_en = 0; gate_pin = 0; settle(5);
    toggle_en = 1; settle(4);
    measure("R7 toggle stays clear on re-enable", 16'h0200, 6, 0, 1, 1'b0);
    toggle_en = 0;

    // R5 period pulse source, from reset
    @(negedge clk); rst = 1; gate_en = 1; gate_sel = 2'b01; per_value = 8'd3;
    @(negedge clk);
    @(negedge clk);
    expect_out("R1 reset clears count", 16'h0000, 1, 1'b0, 1, 1'b0);
    rst = 0; per_tick = 1; cnt_tick = 1;
    repeat (20) @(negedge clk);
    per_tick = 0; cnt_tick = 0;
    expect_out("R5 one pulse per four ticks", 16'd4, 0, 0, 0, 0);

    // R6 toggle on period pulses: full period counted
    @(negedge clk); rst = 1; toggle_en = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0; per_tick = 1; cnt_tick = 1;
    repeat (20) @(negedge clk);
    per_tick = 0; cnt_tick = 0;
    expect_out("R6 toggle counts full periods", 16'd8, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule